// File: doc/BRIEF.md
# Multi-Channel Conversion Sequencer with Temperature Averaging

This block schedules conversions for an eight-input converter that also has an internal temperature sensor. A 16-bit command word carries one select bit per voltage input and a bit that turns on a delay mode. The sequencer works through the selected inputs in ascending order. It starts each conversion with a single-cycle start pulse to a converter stub and waits for the stub's done pulse. When the done pulse arrives, it stores the result as a 16-bit word: a 4-bit channel tag on top of 12 data bits.

A free-running timer asks for a temperature conversion once every `TEMP_PERIOD` clock cycles. A pending temperature request takes priority over the next voltage input. Each temperature sample is stored with its own tag and is also folded into a running average. All words are read back one byte at a time through a small register port. The upper byte is read first, and that read captures the whole word, so both bytes always come from the same result. When delay mode is on and the bus-activity input is high, no conversion starts, and the stub is told to pause its bit trials.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, no conversion is started, the command word is 0 (so delay mode is off), and the voltage, temperature and average words all read as 0.
- R2: Command bit 15-i selects voltage input i (bit 15 is input 0, bit 8 is input 7). Each start pulse for a voltage input carries in `cnv_chan` a tag (0 to 7) whose select bit was set.
- R3: While all eight select bits are 0, no voltage conversion is started. Only temperature conversions (tag 8) occur.
- R4: Selected inputs are converted in ascending order. After the highest selected input, the order wraps to the lowest selected input and repeats. `cnv_start` is high for exactly one cycle per conversion.
- R5: A write to the command word restarts the order, so the next voltage conversion is on the lowest input selected by the new word.
- R6: The voltage result word at read address 1 is {channel tag, 12-bit data}. It changes only in the cycle after a done pulse for a voltage conversion.
- R7: A temperature request is raised every `TEMP_PERIOD` cycles. When the sequencer is idle and not held, a pending request is served before any voltage input, with tag 8. Its result is stored at read address 2 as {4'h8, data}.
- R8: The average word at read address 3 is {4'h9, avg}. avg is loaded with the first temperature sample after reset. After that it is updated as avg + floor((sample - avg)/8), with all values as 12-bit two's complement.
- R9: Command bit 5 enables delay mode. With delay mode on, `cnv_hold` follows `bus_busy`, and no start is issued in the cycle after `bus_busy` was sampled high. With delay mode off, `bus_busy` has no effect.
- R10: Byte reads use a one-cycle latency. Read address map: 0 is the command, 1 is voltage, 2 is temperature, 3 is the average. A read with `rd_hi`=1 returns bits 15:8 and captures the word. A following read with `rd_hi`=0 returns bits 7:0 of that captured word.
- R11: Writes to addresses other than 0 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (only 0 is writable) |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Byte read strobe |
| rd_hi | input | 1 | 1: upper byte, captures the word; 0: lower byte of the captured word |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read byte, valid the cycle after the strobe |
| bus_busy | input | 1 | Bus activity flag |
| cnv_start | output | 1 | One-cycle conversion start |
| cnv_chan | output | 4 | Tag of the conversion being run |
| cnv_hold | output | 1 | Bit-trial pause request to the converter |
| cnv_done | input | 1 | Conversion complete pulse |
| cnv_data | input | 12 | Conversion data, valid with `cnv_done` |

## Verification
Every output of this block is registered except `cnv_hold`, which is combinational and appears in the same cycle as `bus_busy`. A start pulse therefore appears one cycle after the idle decision that the bench model makes from the inputs at that edge. A stored result appears one cycle after the done pulse, and a read byte one cycle after its strobe. The bench reference model advances on the same edge with these delays and is compared with the registered outputs at the falling edge that follows. `cnv_hold` is checked shortly after `bus_busy` is driven. Checks of stored words are made only after conversions have stopped or just after a known completion, so that no result can change between the capture and the compare.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CMD_W  = 16;
  localparam int TAG_W  = 4;
  localparam int DATA_W = 12;

  localparam logic [1:0] ADDR_CMD  = 2'd0;
  localparam logic [1:0] ADDR_VOLT = 2'd1;
  localparam logic [1:0] ADDR_TEMP = 2'd2;
  localparam logic [1:0] ADDR_AVG  = 2'd3;

  typedef enum logic {ST_IDLE, ST_WAIT} seq_state_t;

  // One exponential-average step in two's complement with an arithmetic shift.
  function automatic logic [DATA_W-1:0] avg_step(input logic [DATA_W-1:0] avg,
                                                 input logic [DATA_W-1:0] smp,
                                                 input int unsigned shift);
    logic signed [DATA_W:0] diff;
    diff = $signed({smp[DATA_W-1], smp}) - $signed({avg[DATA_W-1], avg});
    diff = diff >>> shift;
    return avg + diff[DATA_W-1:0];
  endfunction

  // Packs a channel tag above a data field.
  function automatic logic [CMD_W-1:0] pack_word(input logic [TAG_W-1:0] tag,
                                                 input logic [DATA_W-1:0] data);
    return {tag, data};
  endfunction
endpackage

// File: rtl/adc_chan_pick.sv
module adc_chan_pick #(
  parameter int NCH = 8,
  localparam int IDXW = $clog2(NCH)
) (
  input  logic [NCH-1:0]  sel,
  input  logic [IDXW-1:0] last,
  output logic            any,
  output logic [IDXW-1:0] nxt
);
  // Circular scan starting just after the last channel; the nearest hit wins.
  always_comb begin
    int idx;
    any = 1'b0;
    nxt = '0;
    for (int k = NCH; k >= 1; k--) begin
      idx = (int'(last) + k) % NCH;
      if (sel[idx]) begin
        any = 1'b1;
        nxt = IDXW'(idx);
      end
    end
  end
endmodule

// File: rtl/adc_temp_avg.sv
module adc_temp_avg import adc_seq_pkg::*; #(
  parameter int NCH       = 8,
  parameter int AVG_SHIFT = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              smp_vld,
  input  logic [DATA_W-1:0] smp,
  output logic [CMD_W-1:0]  temp_word,
  output logic [CMD_W-1:0]  avg_word
);
  localparam logic [TAG_W-1:0] TEMP_TAG = TAG_W'(NCH);
  localparam logic [TAG_W-1:0] AVG_TAG  = TAG_W'(NCH + 1);

  logic              seen_q;
  logic [DATA_W-1:0] avg_q;
  logic [DATA_W-1:0] avg_nxt;

  assign avg_nxt = seen_q ? avg_step(avg_q, smp, AVG_SHIFT) : smp;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      seen_q    <= 1'b0;
      avg_q     <= '0;
      temp_word <= '0;
      avg_word  <= '0;
    end else if (smp_vld) begin
      seen_q    <= 1'b1;
      avg_q     <= avg_nxt;
      temp_word <= pack_word(TEMP_TAG, smp);
      avg_word  <= pack_word(AVG_TAG, avg_nxt);
    end
  end

  a_r8_first_load: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_vld && !seen_q) |=> (avg_word[DATA_W-1:0] == $past(smp)));
endmodule

// File: rtl/adc_byte_rd.sv
module adc_byte_rd import adc_seq_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_en,
  input  logic             rd_hi,
  input  logic [1:0]       rd_addr,
  input  logic [CMD_W-1:0] w_cmd,
  input  logic [CMD_W-1:0] w_volt,
  input  logic [CMD_W-1:0] w_temp,
  input  logic [CMD_W-1:0] w_avg,
  output logic [7:0]       rd_data
);
  logic [CMD_W-1:0] pick;
  logic [CMD_W-1:0] snap_q;

  always_comb begin
    unique case (rd_addr)
      ADDR_CMD:  pick = w_cmd;
      ADDR_VOLT: pick = w_volt;
      ADDR_TEMP: pick = w_temp;
      default:   pick = w_avg;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      snap_q  <= '0;
      rd_data <= '0;
    end else if (rd_en) begin
      if (rd_hi) begin
        snap_q  <= pick;
        rd_data <= pick[CMD_W-1:8];
      end else begin
        rd_data <= snap_q[7:0];
      end
    end
  end

  a_r10_low_from_snap: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_hi) ##1 (rd_en && !rd_hi) |=> (rd_data == $past(snap_q[7:0])));
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl import adc_seq_pkg::*; #(
  parameter int NCH         = 8,
  parameter int TEMP_PERIOD = 250000,
  parameter int AVG_SHIFT   = 3,
  parameter int DLY_BIT     = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [CMD_W-1:0]  wr_data,
  input  logic              rd_en,
  input  logic              rd_hi,
  input  logic [1:0]        rd_addr,
  output logic [7:0]        rd_data,
  input  logic              bus_busy,
  output logic              cnv_start,
  output logic [TAG_W-1:0]  cnv_chan,
  output logic              cnv_hold,
  input  logic              cnv_done,
  input  logic [DATA_W-1:0] cnv_data
);
  localparam int IDXW = $clog2(NCH);
  localparam int TW   = $clog2(TEMP_PERIOD);
  localparam logic [TAG_W-1:0] TEMP_TAG = TAG_W'(NCH);

  logic [CMD_W-1:0] cmd_q;
  logic [NCH-1:0]   chan_sel;
  logic             dly_en;
  logic             held;
  seq_state_t       st_q;
  logic [IDXW-1:0]  last_q;
  logic             pick_any;
  logic [IDXW-1:0]  pick_ch;
  logic [TW-1:0]    tcnt_q;
  logic             temp_pend;
  logic [CMD_W-1:0] volt_word;
  logic [CMD_W-1:0] temp_word;
  logic [CMD_W-1:0] avg_word;

  // Named internal events
  logic cmd_wr, temp_tick, take_temp, take_volt, done_evt, volt_wr, temp_wr;

  // Select field: top bit is channel 0, walking down.
  for (genvar gi = 0; gi < NCH; gi++) begin : g_sel
    assign chan_sel[gi] = cmd_q[CMD_W-1-gi];
  end

  assign dly_en    = cmd_q[DLY_BIT];
  assign held      = dly_en && bus_busy;
  assign cnv_hold  = held;
  assign cmd_wr    = wr_en && (wr_addr == ADDR_CMD);
  assign temp_tick = (tcnt_q == TW'(TEMP_PERIOD - 1));
  assign take_temp = (st_q == ST_IDLE) && !held && temp_pend;
  assign take_volt = (st_q == ST_IDLE) && !held && !temp_pend && pick_any;
  assign done_evt  = (st_q == ST_WAIT) && cnv_done;
  assign volt_wr   = done_evt && (cnv_chan != TEMP_TAG);
  assign temp_wr   = done_evt && (cnv_chan == TEMP_TAG);

  adc_chan_pick #(.NCH(NCH)) u_pick (
    .sel  (chan_sel),
    .last (last_q),
    .any  (pick_any),
    .nxt  (pick_ch)
  );

  // Periodic temperature request
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tcnt_q    <= '0;
      temp_pend <= 1'b0;
    end else begin
      tcnt_q    <= temp_tick ? '0 : tcnt_q + 1'b1;
      temp_pend <= temp_tick || (temp_pend && !take_temp);
    end
  end

  // Command word and conversion sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmd_q     <= '0;
      st_q      <= ST_IDLE;
      cnv_start <= 1'b0;
      cnv_chan  <= '0;
      last_q    <= IDXW'(NCH - 1);
      volt_word <= '0;
    end else begin
      cnv_start <= 1'b0;
      if (take_temp) begin
        cnv_start <= 1'b1;
        cnv_chan  <= TEMP_TAG;
        st_q      <= ST_WAIT;
      end else if (take_volt) begin
        cnv_start <= 1'b1;
        cnv_chan  <= TAG_W'(pick_ch);
        last_q    <= pick_ch;
        st_q      <= ST_WAIT;
      end else if (done_evt) begin
        st_q <= ST_IDLE;
      end
      if (volt_wr) volt_word <= pack_word(cnv_chan, cnv_data);
      if (cmd_wr) begin
        cmd_q  <= wr_data;
        last_q <= IDXW'(NCH - 1);
      end
    end
  end

  adc_temp_avg #(.NCH(NCH), .AVG_SHIFT(AVG_SHIFT)) u_avg (
    .clk       (clk),
    .rst_n     (rst_n),
    .smp_vld   (temp_wr),
    .smp       (cnv_data),
    .temp_word (temp_word),
    .avg_word  (avg_word)
  );

  adc_byte_rd u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_en   (rd_en),
    .rd_hi   (rd_hi),
    .rd_addr (rd_addr),
    .w_cmd   (cmd_q),
    .w_volt  (volt_word),
    .w_temp  (temp_word),
    .w_avg   (avg_word),
    .rd_data (rd_data)
  );

  a_r4_start_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    cnv_start |=> !cnv_start);

  a_r9_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (dly_en && bus_busy) |=> !cnv_start);

  a_r2_only_selected: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_start && (cnv_chan != TEMP_TAG)) |->
      ((($past(chan_sel) >> cnv_chan[IDXW-1:0]) & NCH'(1)) != '0));

  a_r3_empty_no_volt: assert property (@(posedge clk) disable iff (!rst_n)
    (cnv_start && ($past(chan_sel) == '0)) |-> (cnv_chan == TEMP_TAG));

  a_r6_word_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !volt_wr |=> $stable(volt_word));

  a_r7_temp_first: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE && temp_pend && !held) |=> (cnv_start && cnv_chan == TEMP_TAG));
endmodule

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int P = 600;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic        rd_hi = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        bus_busy = 1'b0;
  logic        cnv_start;
  logic [3:0]  cnv_chan;
  logic        cnv_hold;
  logic        cnv_done = 1'b0;
  logic [11:0] cnv_data = '0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  adc_seq_ctrl #(.TEMP_PERIOD(P)) uut (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // ---------------- converter stub ----------------
  int cd = 0;
  int nconv = 0;
  int stub_ch = 0;
  int ntemp = 0;
  int tsamp[$];
  int last_vword = 0;
  always @(negedge clk) begin
    cnv_done <= 1'b0;
    if (cnv_start) begin
      stub_ch = cnv_chan;
      cd = 2 + (nconv % 3);
      nconv++;
    end else if (cd > 0 && !cnv_hold) begin
      cd--;
      if (cd == 0) begin
        int d;
        if (stub_ch == 8) begin
          d = ((ntemp * 911) ^ 12'h800) & 12'hFFF;
          ntemp++;
          tsamp.push_back(d);
        end else begin
          d = (stub_ch * 300 + nconv * 17) & 12'hFFF;
          last_vword = (stub_ch << 12) | d;
        end
        cnv_done <= 1'b1;
        cnv_data <= 12'(d);
      end
    end
  end

  // ---------------- start monitor ----------------
  int vstarts[$];
  int tstart_cyc[$];
  always @(negedge clk) begin
    if (rst_n && cnv_start) begin
      if (cnv_chan == 4'd8) tstart_cyc.push_back(cyc);
      else vstarts.push_back(int'(cnv_chan));
    end
  end

  // ---------------- behavioural reference model ----------------
  int m_cmd, m_last, m_busy, m_chan, m_start, m_pend, m_cnt;
  int m_volt, m_temp, m_avg, m_seen, m_latch, m_rd;

  function automatic int sel_bit(input int cmd, input int ch);
    return (cmd >> (15 - ch)) & 1;
  endfunction

  function automatic int sx12(input int v);
    return (v & 12'h800) ? (v & 12'hFFF) - 4096 : (v & 12'hFFF);
  endfunction

  function automatic int fdiv8(input int d);
    return (d >= 0) ? d / 8 : -((-d + 7) / 8);
  endfunction

  function automatic int mword(input int a);
    case (a)
      0: return m_cmd;
      1: return m_volt;
      2: return m_temp;
      default: return m_avg;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rst_n) begin
      m_cmd = 0; m_last = 7; m_busy = 0; m_chan = 0; m_start = 0; m_pend = 0;
      m_cnt = 0; m_volt = 0; m_temp = 0; m_avg = 0; m_seen = 0; m_latch = 0; m_rd = 0;
    end else begin
      int n_last, n_pend, n_rd, n_latch, tick, took_t, blocked;
      n_last = m_last; n_rd = m_rd; n_latch = m_latch; took_t = 0;
      tick = (m_cnt == P - 1);
      blocked = ((m_cmd >> 5) & 1) && bus_busy;
      if (rd_en) begin
        if (rd_hi) begin n_latch = mword(rd_addr); n_rd = (n_latch >> 8) & 255; end
        else n_rd = m_latch & 255;
      end
      if (m_busy == 0) begin
        m_start = 0;
        if (!blocked && m_pend) begin
          m_start = 1; m_chan = 8; m_busy = 1; took_t = 1;
        end else if (!blocked) begin
          for (int k = 1; k <= 8; k++) begin
            int c;
            c = (m_last + k) % 8;
            if (m_start == 0 && sel_bit(m_cmd, c)) begin
              m_start = 1; m_chan = c; m_busy = 1; n_last = c;
            end
          end
        end
      end else begin
        m_start = 0;
        if (cnv_done) begin
          m_busy = 0;
          if (m_chan == 8) begin
            int s;
            s = sx12(cnv_data);
            m_avg = m_seen ? sx12(m_avg) + fdiv8(s - sx12(m_avg)) : s;
            m_avg = m_avg & 12'hFFF;
            m_seen = 1;
            m_temp = (8 << 12) | cnv_data;
            m_avg = (9 << 12) | m_avg;
          end else begin
            m_volt = (m_chan << 12) | cnv_data;
          end
        end
      end
      n_pend = tick || (m_pend && !took_t);
      m_cnt = tick ? 0 : m_cnt + 1;
      m_pend = n_pend;
      if (wr_en && wr_addr == 2'd0) begin m_cmd = wr_data; n_last = 7; end
      m_last = n_last; m_rd = n_rd; m_latch = n_latch;
    end
  end

  // per-cycle comparison of registered outputs
  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 cnv_start vs model", cnv_start, m_start);
      if (m_start) chk("R2 cnv_chan vs model", cnv_chan, m_chan);
      chk("R10 rd_data vs model", rd_data, m_rd);
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 2'(a); wr_data = 16'(d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd_word(input int a, output int w);
    int hi;
    @(negedge clk);
    rd_en = 1'b1; rd_hi = 1'b1; rd_addr = 2'(a);
    @(negedge clk);
    hi = rd_data;
    rd_hi = 1'b0;
    @(negedge clk);
    w = (hi << 8) | rd_data;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic new_cmd(input int d);
    wr(0, d);
    @(negedge clk);
    vstarts.delete();
  endtask

  function automatic int exp_avg();
    int a;
    a = 0;
    foreach (tsamp[i]) a = (i == 0) ? sx12(tsamp[i]) : a + fdiv8(sx12(tsamp[i]) - a);
    return (9 << 12) | (a & 12'hFFF);
  endfunction

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      finish_run();
    end
  end

  initial begin
    int w, n0;
    idle(4);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 no start after reset", cnv_start, 0);
    rd_word(0, w); chk("R1 command word zero", w, 0);
    rd_word(1, w); chk("R1 voltage word zero", w, 0);
    rd_word(2, w); chk("R1 temperature word zero", w, 0);
    rd_word(3, w); chk("R1 average word zero", w, 0);
    bus_busy = 1'b1; #1;
    chk("R9 delay off at reset, hold low", cnv_hold, 0);
    bus_busy = 1'b0;

    // R2/R4: channels 2,5,6 in ascending order with wrap
    new_cmd(16'h2600);
    while (vstarts.size() < 6) @(negedge clk);
    chk("R4 order slot0", vstarts[0], 2);
    chk("R4 order slot1", vstarts[1], 5);
    chk("R4 order slot2", vstarts[2], 6);
    chk("R4 wrap slot3", vstarts[3], 2);
    chk("R4 order slot4", vstarts[4], 5);
    chk("R2 order slot5", vstarts[5], 6);

    // R5: restart at lowest of new selection (1 and 7)
    new_cmd(16'h4100);
    while (vstarts.size() < 3) @(negedge clk);
    chk("R5 first after rewrite", vstarts[0], 1);
    chk("R5 second after rewrite", vstarts[1], 7);
    chk("R5 wrap after rewrite", vstarts[2], 1);

    // R6: stable voltage word after sequence stops
    new_cmd(16'h0000);
    idle(20);
    rd_word(1, w);
    chk("R6 voltage word tag and data", w, last_vword);
    chk("R6 tag in top nibble", w >> 12, last_vword >> 12);

    // R11: write to non-command address ignored
    wr(1, 16'hFFFF);
    wr(2, 16'h1234);
    rd_word(1, w); chk("R11 voltage word unchanged", w, last_vword);
    rd_word(0, w); chk("R11 command word unchanged", w, 0);

    // R3/R7: empty selection, only temperature conversions
    while (tstart_cyc.size() < 3) @(negedge clk);
    chk("R3 no voltage starts while empty", vstarts.size(), 0);
    chk("R7 temperature interval", tstart_cyc[2] - tstart_cyc[1], P);
    idle(20);
    rd_word(2, w);
    chk("R7 temperature word", w, (8 << 12) | tsamp[tsamp.size()-1]);
    rd_word(3, w);
    chk("R8 running average", w, exp_avg());

    // R9: delay mode with channel 0
    new_cmd(16'h8020);
    idle(10);
    bus_busy = 1'b1; #1;
    chk("R9 hold follows busy", cnv_hold, 1);
    idle(2);
    n0 = vstarts.size() + tstart_cyc.size();
    idle(40);
    chk("R9 no start while busy", vstarts.size() + tstart_cyc.size(), n0);
    bus_busy = 1'b0;
    idle(30);
    chk("R9 starts resume", int'(vstarts.size() + tstart_cyc.size() > n0), 1);
    new_cmd(16'h8000);
    bus_busy = 1'b1; #1;
    chk("R9 hold low when mode off", cnv_hold, 0);
    idle(40);
    chk("R9 busy ignored when mode off", int'(vstarts.size() > 3), 1);
    bus_busy = 1'b0;

    // R8 again after more samples, selection cleared
    new_cmd(16'h0000);
    while (tstart_cyc.size() < 6) @(negedge clk);
    idle(20);
    rd_word(3, w);
    chk("R8 average after more samples", w, exp_avg());

    // R10: coherent reads during active sequencing
    new_cmd(16'hFF00);
    for (int i = 0; i < 8; i++) begin
      rd_word(1, w);
      chk("R10 tag is a voltage channel", int'((w >> 12) < 8), 1);
    end
    idle(5);
    finish_run();
  end
endmodule